// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Bank

This block is a bank of 32 general-purpose pins with a small word-wide register interface. Software drives pin values through an output register and picks each pin's direction. It reads pin levels through a data-in view that can invert each pin. Every incoming pin passes through a two-flop synchroniser before any logic looks at it.

Each pin can raise an interrupt in two ways. The level path passes the adjusted data-in bit through a level mask. The edge path latches rising transitions of the adjusted bit into a sticky edge cause register. Software clears that register by writing zeros, and an edge mask gates it. The bank sorts its pins into groups of eight, and each group drives its own summary interrupt line. Setting a pin's polarity bit turns the level path into an active-low detector and the edge path into a falling-edge detector.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the output register is 0, the direction register is all ones, and the polarity, edge cause, edge mask and level mask registers are 0. As a result pin_oe is 0, pin_out is 0 and irq is 0.
- R2: The output register (offset 0x00) drives pin_out. In the direction register (offset 0x04) a 1 makes a pin an input, so pin_oe for each pin is the inverse of its direction bit.
- R3: The output, direction, polarity (0x0C), edge mask (0x18) and level mask (0x1C) registers read back what was written. Any offset outside the map, including 0x08, reads 0 and ignores writes. Writes to data-in (0x10) have no effect.
- R4: A change on pin_in first shows in data-in after the second rising clock edge. It does not show after the first.
- R5: Data-in (0x10) reads as the synchronised pin value XOR the polarity register.
- R6: An edge cause bit (0x14) is set one cycle after its data-in bit goes from 0 to 1, and it stays set after the pin returns. With its polarity bit at 1, a falling pin sets the bit.
- R7: A write to 0x14 clears each cause bit written as 0 and leaves each bit written as 1 unchanged.
- R8: When a new edge and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R9: irq[g] is high while any pin 8g..8g+7 has both its data-in bit and its level mask bit at 1, and it follows the synchronised pin.
- R10: irq[g] is high while any pin 8g..8g+7 has both its edge cause bit and its edge mask bit at 1.
- R11: A cause whose mask bit is 0 never reaches irq, but an edge cause bit still latches while its mask is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Driven pin values |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 4 | Summary interrupts, one per group of eight pins |

## Verification
The bench builds the block with its defaults: 32 pins in four groups of eight. This lets it place interrupt sources in different groups, such as pins 12 and 31, and confirm that each one lights only its own irq bit. With this width the map offsets match the 5-bit address, so the bench can also hit the unmapped slot at 0x08. The synchroniser depth is fixed, which means the bench can time a clearing write to land in exactly the cycle a new edge is latched.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_OUT    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_POL    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_ECAUSE = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_EMASK  = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_LMASK  = 5'h1C;

  typedef enum logic [2:0] {
    SEL_OUT,
    SEL_DIR,
    SEL_POL,
    SEL_DIN,
    SEL_ECAUSE,
    SEL_EMASK,
    SEL_LMASK,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_OUT:    s = SEL_OUT;
      OFS_DIR:    s = SEL_DIR;
      OFS_POL:    s = SEL_POL;
      OFS_DIN:    s = SEL_DIN;
      OFS_ECAUSE: s = SEL_ECAUSE;
      OFS_EMASK:  s = SEL_EMASK;
      OFS_LMASK:  s = SEL_LMASK;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

  // cycles since reset, saturating, so the delay check never looks before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  AST_SYNC_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (q == $past(d, 2))); // R4

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] cause,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] pol_q,
  output logic [WIDTH-1:0] emask_q,
  output logic [WIDTH-1:0] lmask_q,
  output logic [WIDTH-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_OUT:   out_q   <= wdata;
        SEL_DIR:   dir_q   <= wdata;
        SEL_POL:   pol_q   <= wdata;
        SEL_EMASK: emask_q <= wdata;
        SEL_LMASK: lmask_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_OUT:    rdata = out_q;
      SEL_DIR:    rdata = dir_q;
      SEL_POL:    rdata = pol_q;
      SEL_DIN:    rdata = din;
      SEL_ECAUSE: rdata = cause;
      SEL_EMASK:  rdata = emask_q;
      SEL_LMASK:  rdata = lmask_q;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             clr_wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] cause_q,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] clr_hit
);
  logic [WIDTH-1:0] din_prev_q;

  function automatic logic [WIDTH-1:0] rising(input logic [WIDTH-1:0] cur,
                                              input logic [WIDTH-1:0] prev);
    return cur & ~prev;
  endfunction

  // new edges are ORed in after the clear, so an edge beats a same-cycle clear
  function automatic logic [WIDTH-1:0] next_cause(input logic [WIDTH-1:0] cur,
                                                  input logic [WIDTH-1:0] kill,
                                                  input logic [WIDTH-1:0] set);
    return (cur & ~kill) | set;
  endfunction

  assign rise    = rising(din, din_prev_q);
  assign clr_hit = clr_wr ? ~wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_prev_q <= '0;
      cause_q    <= '0;
    end else begin
      din_prev_q <= din;
      cause_q    <= next_cause(cause_q, clr_hit, rise);
    end
  end

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((cause_q & $past(rise)) == $past(rise))); // R8

  AST_CLEAR_ONLY_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cause_q) & ~cause_q & ~$past(clr_hit)) == '0)); // R7

  AST_SET_ONLY_BY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(cause_q) & cause_q & ~$past(rise)) == '0)); // R6

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int WIDTH   = 32,
  parameter int GROUP_W = 8,
  localparam int NUM_GROUPS = WIDTH / GROUP_W
) (
  input  logic [WIDTH-1:0]      level_hit,
  input  logic [WIDTH-1:0]      edge_hit,
  output logic [NUM_GROUPS-1:0] irq
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign irq[g] = |(level_hit[g*GROUP_W +: GROUP_W] | edge_hit[g*GROUP_W +: GROUP_W]);
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int GROUP_W  = 8,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_PINS-1:0]   wdata,
  output logic [NUM_PINS-1:0]   rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_GROUPS-1:0] irq
);
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] sync_q, din;
  logic [NUM_PINS-1:0] out_q, dir_q, pol_q, emask_q, lmask_q;
  logic [NUM_PINS-1:0] cause_q, rise, clr_hit;
  logic [NUM_PINS-1:0] level_hit, edge_hit;

  assign sel = decode_addr(addr);

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  assign din = sync_q ^ pol_q;

  gpio_regs #(.WIDTH(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .din(din), .cause(cause_q),
    .out_q(out_q), .dir_q(dir_q), .pol_q(pol_q),
    .emask_q(emask_q), .lmask_q(lmask_q), .rdata(rdata)
  );

  gpio_edge_cause #(.WIDTH(NUM_PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(din),
    .clr_wr(wr_en && (sel == SEL_ECAUSE)), .wdata(wdata),
    .cause_q(cause_q), .rise(rise), .clr_hit(clr_hit)
  );

  assign level_hit = din & lmask_q;
  assign edge_hit  = cause_q & emask_q;

  gpio_irq_merge #(.WIDTH(NUM_PINS), .GROUP_W(GROUP_W)) u_merge (
    .level_hit(level_hit), .edge_hit(edge_hit), .irq(irq)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((lmask_q == '0) && (emask_q == '0)) |-> (irq == '0)); // R11

  AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel == SEL_DIR)) |=> (pin_oe == ~$past(wdata))); // R2

endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  gpio_irq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_GAP = 5'h08, A_POL = 5'h0C,
                         A_DIN = 5'h10, A_EC = 5'h14, A_EM = 5'h18, A_LM = 5'h1C;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata, exp, req);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk(A_OUT, 32'h0, "R1 out");
    rd_chk(A_DIR, 32'hFFFF_FFFF, "R1 dir");
    rd_chk(A_POL, 32'h0, "R1 pol");
    rd_chk(A_EC, 32'h0, "R1 ecause");
    rd_chk(A_EM, 32'h0, "R1 emask");
    rd_chk(A_LM, 32'h0, "R1 lmask");
    chk({28'h0, irq}, 32'h0, "R1 irq");
    chk(pin_oe, 32'h0, "R1 oe");
    chk(pin_out, 32'h0, "R1 pin_out");
  endtask

  task automatic t_regs;
    wr(A_OUT, 32'hA5A5_0F0F);
    wr(A_DIR, 32'hFFFF_0000);
    chk(pin_out, 32'hA5A5_0F0F, "R2 pin_out");
    chk(pin_oe, 32'h0000_FFFF, "R2 oe");
    rd_chk(A_OUT, 32'hA5A5_0F0F, "R3 out readback");
    rd_chk(A_DIR, 32'hFFFF_0000, "R3 dir readback");
    wr(A_GAP, 32'hFFFF_FFFF);
    rd_chk(A_GAP, 32'h0, "R3 gap reads zero");
    chk(pin_out, 32'hA5A5_0F0F, "R3 gap write ignored");
    wr(A_EM, 32'hDEAD_BEEF);
    rd_chk(A_EM, 32'hDEAD_BEEF, "R3 emask readback");
    wr(A_EM, 32'h0);
    wr(A_LM, 32'h1234_8765);
    rd_chk(A_LM, 32'h1234_8765, "R3 lmask readback");
    wr(A_LM, 32'h0);
    wr(A_POL, 32'h0F0F_0000);
    rd_chk(A_POL, 32'h0F0F_0000, "R3 pol readback");
    wr(A_POL, 32'h0);
    wr(A_DIN, 32'hFFFF_FFFF);
    rd_chk(A_DIN, 32'h0, "R3 din write ignored");
  endtask

  task automatic t_sync_pol;
    pin_in = 32'h1234_5678;
    wait_cyc(1);
    rd_chk(A_DIN, 32'h0, "R4 not yet after one edge");
    wait_cyc(1);
    rd_chk(A_DIN, 32'h1234_5678, "R4 visible after two edges");
    wr(A_POL, 32'hFFFF_0000);
    rd_chk(A_DIN, 32'hEDCB_5678, "R5 polarity xor");
    wr(A_POL, 32'h0);
    pin_in = '0;
    wait_cyc(3);
    wr(A_EC, 32'h0);
    rd_chk(A_EC, 32'h0, "R7 clear all");
  endtask

  task automatic t_edge;
    pin_in = 32'h8;
    wait_cyc(2);
    rd_chk(A_EC, 32'h0, "R6 not before latch");
    wait_cyc(1);
    rd_chk(A_EC, 32'h8, "R6 rising latched");
    pin_in = '0;
    wait_cyc(3);
    rd_chk(A_EC, 32'h8, "R6 sticky");
    wr(A_POL, 32'h20);
    wait_cyc(1);
    wr(A_EC, 32'hFFFF_FFDF);
    rd_chk(A_EC, 32'h8, "R7 zero bit cleared, one bit kept");
    pin_in = 32'h20;
    wait_cyc(3);
    rd_chk(A_EC, 32'h8, "R6 rising pin ignored when inverted");
    pin_in = '0;
    wait_cyc(3);
    rd_chk(A_EC, 32'h28, "R6 falling pin latched when inverted");
    wr(A_EC, 32'hFFFF_FFF7);
    rd_chk(A_EC, 32'h20, "R7 partial clear");
    wr(A_POL, 32'h0);
    wr(A_EC, 32'h0);
  endtask

  task automatic t_collide;
    pin_in = 32'h200;
    wait_cyc(2);
    wr(A_EC, 32'h0);
    rd_chk(A_EC, 32'h200, "R8 edge wins over clear");
    wr(A_EC, 32'h0);
    rd_chk(A_EC, 32'h0, "R7 later clear works");
  endtask

  task automatic t_level;
    pin_in = 32'h8000_1000;
    wait_cyc(2);
    wr(A_LM, 32'h1000);
    chk({28'h0, irq}, 32'h2, "R9 pin 12 on group 1");
    wr(A_LM, 32'h8000_1000);
    chk({28'h0, irq}, 32'hA, "R9 pins 12 and 31");
    wr(A_LM, 32'h0000_0800);
    chk({28'h0, irq}, 32'h0, "R11 high pins masked");
    wr(A_LM, 32'h1000);
    pin_in = 32'h8000_0000;
    wait_cyc(1);
    chk({28'h0, irq}, 32'h2, "R9 level still set after one edge");
    wait_cyc(1);
    chk({28'h0, irq}, 32'h0, "R9 level follows pin");
    wr(A_LM, 32'h0);
    pin_in = '0;
    wait_cyc(3);
    wr(A_EC, 32'h0);
  endtask

  task automatic t_edge_irq;
    wr(A_EM, 32'h0010_0000);
    pin_in = 32'h0010_0000;
    wait_cyc(2);
    chk({28'h0, irq}, 32'h0, "R10 not before latch");
    wait_cyc(1);
    chk({28'h0, irq}, 32'h4, "R10 pin 20 on group 2");
    pin_in = 32'h0010_0001;
    wait_cyc(3);
    rd_chk(A_EC, 32'h0010_0001, "R11 masked cause still latches");
    chk({28'h0, irq}, 32'h4, "R11 masked cause silent");
    wr(A_EM, 32'h0010_0001);
    chk({28'h0, irq}, 32'h5, "R10 unmask group 0");
    wr(A_EC, 32'hFFEF_FFFF);
    chk({28'h0, irq}, 32'h1, "R10 cleared cause drops irq");
    wr(A_EC, 32'h0);
    chk({28'h0, irq}, 32'h0, "R10 all clear");
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_sync_pol();
    t_edge();
    t_collide();
    t_level();
    t_edge_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule